// File: doc/BRIEF.md
# Integer Execute Stage

This block is the integer execute stage of a 32-bit load/store processor with 32 general registers. The decode stage hands it an operation code, the first source value, the second source value, a 16-bit immediate, a flag that selects the immediate as the second operand, a destination register index and a valid strobe. The block extends the immediate as the operation requires and computes the result. One clock later it presents the result, a destination write enable and the destination index to the register file.

The block keeps no condition codes. A comparison writes 0 or 1 into a general register. The load-high operation puts the immediate into the upper half of the word. Signed add and subtract report two's-complement overflow on a flag that the surrounding pipeline may use to trap. Register 0 is hard-wired to zero, so the block never asserts the write enable for destination 0.

Top module: `exu_top`

## Requirements
- R1: Outputs are registered. For an operation presented with `in_valid` high on a clock edge, `res`, `wr_idx`, `wr_en` and `ovf` show its outcome after that edge. After an edge where `in_valid` was low, `wr_en`, `ovf` and `res` are 0. While reset is active, all outputs are 0.
- R2: Add (code 0), unsigned add (code 1), subtract (code 2) and unsigned subtract (code 3) produce the sum or difference modulo 2^32.
- R3: `ovf` is 1 for add (code 0) or subtract (code 2) when the signed result overflows 32 bits. It is always 0 for unsigned add (code 1) and unsigned subtract (code 3).
- R4: AND (code 4), OR (code 5) and XOR (code 6) produce the bitwise result.
- R5: Shift left logical (code 7), shift right logical (code 8) and shift right arithmetic (code 9) shift the first operand by the low 5 bits of the second operand only.
- R6: The signed set-conditional operations write 1 when the relation holds and 0 otherwise, comparing as two's-complement values. The codes are: less-than 11, greater-than 12, less-or-equal 13, greater-or-equal 14, equal 15, not-equal 16.
- R7: The unsigned set-conditional operations compare as unsigned values and write 1 or 0. The codes are: less-than 17, greater-than 18, less-or-equal 19, greater-or-equal 20.
- R8: Load-high (code 10) produces the immediate in bits 31..16 and zeros in bits 15..0. It ignores both source values.
- R9: When `use_imm` is 1, the immediate replaces the second source value. Codes 0, 2 and 11 through 16 sign-extend the immediate. All other codes zero-extend it.
- R10: A valid operation whose destination index is 0 leaves `wr_en` at 0. The result is still computed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 5 | Operation code |
| use_imm | input | 1 | Select immediate as second operand |
| src_a | input | 32 | First source value |
| src_b | input | 32 | Second source value |
| imm | input | 16 | Immediate field |
| dest | input | 5 | Destination register index |
| res | output | 32 | Registered result |
| wr_en | output | 1 | Registered destination write enable |
| wr_idx | output | 5 | Registered destination index |
| ovf | output | 1 | Registered signed overflow flag |

## Verification
The hardest cases to reach are the ones where the immediate extension and the comparison sign interact. One example is a signed less-or-equal against an immediate of 0xFFFF, which must mean -1. Another is an unsigned add of the same immediate, which must mean 65535. Operands are picked so that the signed and unsigned readings give different answers. The overflow edges are also driven directly: the largest positive value plus one, and the most negative value minus one. In each case the scoreboard tells a sign-extension mistake apart from a flag mistake.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,  OP_ADDU = 5'd1,  OP_SUB  = 5'd2,  OP_SUBU = 5'd3,
    OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,
    OP_SLL  = 5'd7,  OP_SRL  = 5'd8,  OP_SRA  = 5'd9,
    OP_LHI  = 5'd10,
    OP_SLT  = 5'd11, OP_SGT  = 5'd12, OP_SLE  = 5'd13, OP_SGE  = 5'd14,
    OP_SEQ  = 5'd15, OP_SNE  = 5'd16,
    OP_SLTU = 5'd17, OP_SGTU = 5'd18, OP_SLEU = 5'd19, OP_SGEU = 5'd20
  } op_e;

  function automatic logic imm_is_signed(op_e o);
    return (o == OP_ADD) || (o == OP_SUB) || (o >= OP_SLT && o <= OP_SNE);
  endfunction

  function automatic logic is_setcond(op_e o);
    return (o >= OP_SLT) && (o <= OP_SGEU);
  endfunction
endpackage

// File: rtl/exu_opsel.sv
module exu_opsel
  import exu_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  op_e            op,
  input  logic           use_imm,
  input  logic [W-1:0]   src_b,
  input  logic [IW-1:0]  imm,
  output logic [W-1:0]   opb,
  output logic           imm_sext_w
);
  localparam int XW = W - IW;

  assign imm_sext_w = use_imm && imm_is_signed(op);

  always_comb begin
    if (!use_imm)        opb = src_b;
    else if (imm_sext_w) opb = {{XW{imm[IW-1]}}, imm};
    else                 opb = {{XW{1'b0}}, imm};
  end

  // R9: a zero-extended immediate never fills the upper bits
  always_comb begin
    if (use_imm && !imm_sext_w)
      assert_zext_upper_R9: assert (opb[W-1:IW] == '0);
  end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  op_e           op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [IW-1:0] imm,
  output logic [W-1:0]  result,
  output logic          ovf_w,
  output logic          set_op_w
);
  localparam int SHW = $clog2(W);

  function automatic logic [W:0] addsub(logic [W-1:0] x, logic [W-1:0] y, logic sub);
    logic [W-1:0] yy;
    logic [W-1:0] s;
    logic         v;
    yy = sub ? ~y : y;
    s  = x + yy + {{(W-1){1'b0}}, sub};
    v  = (x[W-1] == yy[W-1]) && (s[W-1] != x[W-1]);
    return {v, s};
  endfunction

  function automatic logic relation(op_e o, logic [W-1:0] x, logic [W-1:0] y);
    logic lt_s, lt_u, eq;
    lt_s = $signed(x) < $signed(y);
    lt_u = x < y;
    eq   = (x == y);
    case (o)
      OP_SLT:  return lt_s;
      OP_SGT:  return !lt_s && !eq;
      OP_SLE:  return lt_s || eq;
      OP_SGE:  return !lt_s;
      OP_SEQ:  return eq;
      OP_SNE:  return !eq;
      OP_SLTU: return lt_u;
      OP_SGTU: return !lt_u && !eq;
      OP_SLEU: return lt_u || eq;
      OP_SGEU: return !lt_u;
      default: return 1'b0;
    endcase
  endfunction

  logic [W:0]     as_w;
  logic [SHW-1:0] sh_w;

  assign as_w     = addsub(a, b, (op == OP_SUB) || (op == OP_SUBU));
  assign sh_w     = b[SHW-1:0];
  assign set_op_w = is_setcond(op);
  assign ovf_w    = ((op == OP_ADD) || (op == OP_SUB)) && as_w[W];

  always_comb begin
    case (op)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result = as_w[W-1:0];
      OP_AND: result = a & b;
      OP_OR:  result = a | b;
      OP_XOR: result = a ^ b;
      OP_SLL: result = a << sh_w;
      OP_SRL: result = a >> sh_w;
      OP_SRA: result = $unsigned($signed(a) >>> sh_w);
      OP_LHI: result = {imm, {(W-IW){1'b0}}};
      default: result = set_op_w ? {{(W-1){1'b0}}, relation(op, a, b)} : '0;
    endcase
  end
endmodule

// File: rtl/exu_top.sv
module exu_top
  import exu_pkg::*;
#(
  parameter int W   = 32,
  parameter int IW  = 16,
  parameter int NREG = 32,
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OP_W-1:0] op,
  input  logic            use_imm,
  input  logic [W-1:0]    src_a,
  input  logic [W-1:0]    src_b,
  input  logic [IW-1:0]   imm,
  input  logic [RW-1:0]   dest,
  output logic [W-1:0]    res,
  output logic            wr_en,
  output logic [RW-1:0]   wr_idx,
  output logic            ovf
);
  op_e          op_w;
  logic [W-1:0] opb_w;
  logic [W-1:0] alu_res_w;
  logic         alu_ovf_w;
  logic         set_op_w;
  logic         imm_sext_w;
  logic         dest_zero_w;

  assign op_w        = op_e'(op);
  assign dest_zero_w = (dest == '0);

  exu_opsel #(.W(W), .IW(IW)) opsel_i (
    .op(op_w), .use_imm(use_imm), .src_b(src_b), .imm(imm),
    .opb(opb_w), .imm_sext_w(imm_sext_w)
  );

  exu_alu #(.W(W), .IW(IW)) alu_i (
    .op(op_w), .a(src_a), .b(opb_w), .imm(imm),
    .result(alu_res_w), .ovf_w(alu_ovf_w), .set_op_w(set_op_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res    <= '0;
      wr_en  <= 1'b0;
      wr_idx <= '0;
      ovf    <= 1'b0;
    end else begin
      res    <= in_valid ? alu_res_w : '0;
      wr_en  <= in_valid && !dest_zero_w;
      wr_idx <= dest;
      ovf    <= in_valid && alu_ovf_w;
    end
  end

  assert_wr_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx != '0));

  assert_wr_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!wr_en && !ovf));

  assert_setcond_bool_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && set_op_w) |=> (res[W-1:1] == '0));

  assert_unsigned_no_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_w == OP_ADDU || op_w == OP_SUBU)) |=> !ovf);

  assert_lhi_low_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_w == OP_LHI) |=> (res[W-IW-1:0] == '0));
endmodule

// File: tb/exu_top_tb_top.sv
module exu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  op = '0;
  logic        use_imm = 1'b0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [15:0] imm = '0;
  logic [4:0]  dest = '0;
  logic [31:0] res;
  logic        wr_en, ovf;
  logic [4:0]  wr_idx;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct packed {
    logic [31:0] r;
    logic        we;
    logic [4:0]  idx;
    logic        ov;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  exu_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .use_imm(use_imm),
    .src_a(src_a), .src_b(src_b), .imm(imm), .dest(dest),
    .res(res), .wr_en(wr_en), .wr_idx(wr_idx), .ovf(ovf)
  );

  function automatic exp_t model(int code, bit [31:0] a, bit [31:0] b, bit [15:0] im,
                                 bit ui, bit [4:0] d, bit v);
    exp_t e;
    bit [31:0] bb;
    bit sx;
    longint sa, sb, wide;
    sx = (code == 0) || (code == 2) || (code >= 11 && code <= 16);
    if (ui) bb = sx ? 32'($signed(im)) : {16'd0, im};
    else    bb = b;
    sa = longint'($signed(a));
    sb = longint'($signed(bb));
    e.r = 0; e.ov = 0;
    case (code)
      0, 1: begin e.r = a + bb; wide = sa + sb; end
      2, 3: begin e.r = a - bb; wide = sa - sb; end
      4: e.r = a & bb;
      5: e.r = a | bb;
      6: e.r = a ^ bb;
      7: e.r = a << (bb % 32);
      8: e.r = a >> (bb % 32);
      9: e.r = 32'(sa >>> (bb % 32));
      10: e.r = {im, 16'h0000};
      11: e.r = 32'(sa < sb);
      12: e.r = 32'(sa > sb);
      13: e.r = 32'(sa <= sb);
      14: e.r = 32'(sa >= sb);
      15: e.r = 32'(a == bb);
      16: e.r = 32'(a != bb);
      17: e.r = 32'(a < bb);
      18: e.r = 32'(a > bb);
      19: e.r = 32'(a <= bb);
      20: e.r = 32'(a >= bb);
      default: e.r = 0;
    endcase
    if ((code == 0 || code == 2) && (wide > 64'sd2147483647 || wide < -64'sd2147483648))
      e.ov = 1;
    if (!v) begin e.r = 0; e.ov = 0; end
    e.we  = v && (d != 0);
    e.idx = d;
    return e;
  endfunction

  task automatic drive(bit v, int code, bit [31:0] a, bit [31:0] b, bit [15:0] im,
                       bit ui, bit [4:0] d, string tag);
    @(negedge clk);
    in_valid = v; op = 5'(code); src_a = a; src_b = b; imm = im; use_imm = ui; dest = d;
    exp_q.push_back(model(code, a, b, im, ui, d, v));
    tag_q.push_back(tag);
  endtask

  // monitor: compares each registered outcome one edge after its inputs
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && exp_q.size() > 0) begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_vec++;
        if ({res, wr_en, wr_idx, ovf} !== e) begin
          n_bad++;
          $display("FAIL %s: got res=%h we=%b idx=%0d ovf=%b, expected res=%h we=%b idx=%0d ovf=%b",
                   t, res, wr_en, wr_idx, ovf, e.r, e.we, e.idx, e.ov);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_vec++;
    if ({res, wr_en, wr_idx, ovf} !== '0) begin
      n_bad++;
      $display("FAIL R1 reset: got res=%h we=%b idx=%0d ovf=%b, expected all 0", res, wr_en, wr_idx, ovf);
    end
    @(negedge clk); rst_n = 1'b1;

    drive(1, 0, 32'd100, 32'd23, 0, 0, 5'd1, "R2 add");
    drive(1, 0, 32'h7fffffff, 32'd1, 0, 0, 5'd2, "R3 add overflow");
    drive(1, 1, 32'h7fffffff, 32'd1, 0, 0, 5'd3, "R3 addu no overflow");
    drive(1, 2, 32'h80000000, 32'd1, 0, 0, 5'd4, "R3 sub overflow");
    drive(1, 3, 32'd0, 32'd1, 0, 0, 5'd5, "R2 subu wrap");
    drive(0, 0, 32'h7fffffff, 32'd1, 0, 0, 5'd6, "R1 idle");
    drive(1, 0, 32'd10, 32'd0, 16'hFFFF, 1, 5'd7, "R9 addi sign-extend");
    drive(1, 1, 32'd10, 32'd0, 16'hFFFF, 1, 5'd8, "R9 addui zero-extend");
    drive(1, 4, 32'hFFFF_FFFF, 32'd0, 16'h8001, 1, 5'd9, "R4 R9 andi zero-extend");
    drive(1, 5, 32'hF0F0_0000, 32'h0000_0F0F, 0, 0, 5'd10, "R4 or");
    drive(1, 6, 32'hAAAA_5555, 32'hFFFF_0000, 0, 0, 5'd11, "R4 xor");
    drive(1, 7, 32'h0000_0003, 32'd33, 0, 0, 5'd12, "R5 sll low bits");
    drive(1, 8, 32'h8000_0000, 32'd4, 0, 0, 5'd13, "R5 srl");
    drive(1, 9, 32'h8000_0000, 32'd36, 0, 0, 5'd14, "R5 sra low bits");
    drive(1, 10, 32'hDEAD_BEEF, 32'h1234_5678, 16'h00A5, 0, 5'd15, "R8 lhi");
    drive(1, 11, 32'hFFFF_FFFF, 32'd1, 0, 0, 5'd16, "R6 slt");
    drive(1, 17, 32'hFFFF_FFFF, 32'd1, 0, 0, 5'd17, "R7 sltu");
    drive(1, 12, 32'd1, 32'h8000_0000, 0, 0, 5'd18, "R6 sgt");
    drive(1, 18, 32'd1, 32'h8000_0000, 0, 0, 5'd19, "R7 sgtu");
    drive(1, 13, 32'hFFFF_FFFF, 32'd0, 16'hFFFF, 1, 5'd20, "R6 R9 slei equal");
    drive(1, 19, 32'd5, 32'd0, 16'hFFFF, 1, 5'd21, "R7 R9 sleui");
    drive(1, 14, 32'h8000_0000, 32'd0, 0, 0, 5'd22, "R6 sge");
    drive(1, 20, 32'h8000_0000, 32'd0, 0, 0, 5'd23, "R7 sgeu");
    drive(1, 15, 32'd7, 32'd7, 0, 0, 5'd24, "R6 seq");
    drive(1, 16, 32'd7, 32'd7, 0, 0, 5'd25, "R6 sne");
    drive(1, 0, 32'd1, 32'd2, 0, 0, 5'd0, "R10 dest zero");
    drive(1, 2, 32'd5, 32'd9, 0, 0, 5'd31, "R2 sub negative");
    drive(0, 1, 32'd0, 32'd0, 0, 0, 5'd0, "R1 idle tail");
    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule